// File: doc/BRIEF.md
# SPI Configuration Host Sequencer

This block sits on the host side of a serial configuration link and loads an image into a target device whose load port behaves as an SPI slave. On a start strobe it pulls the target's reset output low while holding chip-select low. It then releases reset and waits out the target's memory-clear interval. Next it accepts image bytes from a byte-wide ready/valid source and shifts them out most-significant bit first on a generated serial clock, with no pause anywhere in the stream. After the last byte it samples the target's done pin, which passes through a two-flop synchronizer. If done is high it clocks out an exact count of dummy bits and reports success. If done is low it reports a configuration error.

The controller is a single state machine. The states are `ST_IDLE`, `ST_RESET`, `ST_CLEAR`, `ST_FIRST`, `ST_STREAM`, `ST_CHECK` and `ST_TRAIL`, and the transitions are:

| From | To | Condition |
|---|---|---|
| any state | `ST_RESET` | start strobe |
| `ST_RESET` | `ST_CLEAR` | reset-width timer expires |
| `ST_CLEAR` | `ST_FIRST` | clear timer expires |
| `ST_FIRST` | `ST_STREAM` | first byte accepted |
| `ST_STREAM` | `ST_CHECK` | byte boundary after the last byte |
| `ST_STREAM` | `ST_IDLE` | byte boundary with the source empty (underflow) |
| `ST_CHECK` | `ST_TRAIL` | check timer expires and synchronized done is high |
| `ST_CHECK` | `ST_IDLE` | check timer expires and synchronized done is low (error) |
| `ST_TRAIL` | `ST_IDLE` | the last dummy clock completes (success) |

All timing comes from parameters given in system clock cycles: `RST_CYC`, `CLEAR_CYC`, `HALF_DIV`, `CHECK_CYC` and `DUMMY_BITS`. They are set from the system clock frequency.

Top module: `cfg_loader`

## Requirements
- R1: After reset and whenever idle, `busy_o` is 0, `src_ready_o` is 0, and `tgt_rst_n_o`, `tgt_sel_n_o`, `tgt_sck_o` and `tgt_mosi_o` are all parked at 1.
- R2: A start strobe drives `tgt_rst_n_o` low for exactly `RST_CYC` cycles, with `tgt_sel_n_o` low and `busy_o` high. When `tgt_rst_n_o` rises, `tgt_sel_n_o` is low.
- R3: After `tgt_rst_n_o` rises, `tgt_sck_o` shows no rising edge and `src_ready_o` stays low for `CLEAR_CYC` cycles.
- R4: `tgt_sck_o` spends `HALF_DIV` cycles low and then `HALF_DIV` cycles high for each bit. The default period lies between 40 ns and 1 us at 125 MHz. `tgt_mosi_o` changes only while `tgt_sck_o` is low, so it is stable across every rising edge.
- R5: Bytes go out in the order they are accepted, bit 7 first. The rising edges of the whole image are evenly spaced, including across byte boundaries.
- R6: If the source is not valid when a non-last byte finishes, clocking stops at that boundary. `underflow_o` is then set and the block returns to idle.
- R7: When the synchronized done input is high at the end of the check wait, exactly `DUMMY_BITS` further rising edges are sent with `tgt_mosi_o` at 1. Then `ok_o` is set and the block goes idle.
- R8: When done is low at the end of the check wait, `cfg_err_o` is set, no dummy clock is sent, and the block goes idle.
- R9: A start strobe in any state restarts from the reset pulse on the next cycle and clears all status outputs.
- R10: At most one of `ok_o`, `cfg_err_o` and `underflow_o` is high, and it holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins or restarts a load |
| src_data_i | input | 8 | Image byte |
| src_valid_i | input | 1 | Source holds a byte |
| src_last_i | input | 1 | Current byte is the final byte of the image |
| src_ready_o | output | 1 | Byte accepted this cycle when valid |
| tgt_rst_n_o | output | 1 | Target reset, active low |
| tgt_sel_n_o | output | 1 | Target chip-select, active low |
| tgt_sck_o | output | 1 | Generated serial clock |
| tgt_mosi_o | output | 1 | Serial data to the target |
| tgt_done_i | input | 1 | Target done pin, asynchronous |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last load succeeded |
| cfg_err_o | output | 1 | Done was low after the image |
| underflow_o | output | 1 | Source ran dry mid-image |

## Verification
The bench targets four failure modes.
- A byte boundary that inserts or drops a half period: the rising-edge spacing becomes uneven, and the byte-order check catches a misplaced load.
- A dummy counter off by one: the trail has 48 or 50 rising edges instead of 49.
- An underflow that is missed, or flagged on the last byte: the load either hangs or reports the wrong status.
- A restart that leaves stale status set, or that skips the reset pulse: the restart leaves the wrong outputs on the following cycle.

The bench also checks that clocking does not start before the clear time has run out, and that chip-select is low when the target leaves reset.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_CLEAR,
        ST_FIRST,
        ST_STREAM,
        ST_CHECK,
        ST_TRAIL
    } ld_state_t;
endpackage

// File: rtl/cfg_loader_timer.sv
module cfg_loader_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_loader_shift.sv
module cfg_loader_shift #(
    parameter int HALF_DIV = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       sck_o,
    output logic       bit_o,
    output logic       bit_tick_o,
    output logic       byte_tick_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          phase_q;
    logic [7:0]    sreg_q;
    logic [2:0]    bcnt_q;
    logic          edge_now;

    assign edge_now    = run_i && (div_q == DW'(HALF_DIV - 1));
    assign bit_tick_o  = edge_now && phase_q;
    assign byte_tick_o = bit_tick_o && (bcnt_q == 3'd7);
    assign sck_o       = phase_q;
    assign bit_o       = sreg_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b0;
            sreg_q  <= 8'hFF;
            bcnt_q  <= 3'd0;
        end else begin
            if (!run_i) begin
                div_q   <= '0;
                phase_q <= 1'b0;
            end else if (edge_now) begin
                div_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                div_q <= div_q + DW'(1);
            end
            if (load_i) begin
                sreg_q <= byte_i;
                bcnt_q <= 3'd0;
            end else if (bit_tick_o) begin
                sreg_q <= {sreg_q[6:0], 1'b1};
                bcnt_q <= bcnt_q + 3'd1;
            end
        end
    end

    // R4: data must hold while the serial clock is high
    a_r4_bit_holds_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sck_o) && sck_o) |-> $stable(bit_o));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int RST_CYC    = 26,
    parameter int CLEAR_CYC  = 100000,
    parameter int HALF_DIV   = 3,
    parameter int CHECK_CYC  = 4,
    parameter int DUMMY_BITS = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] src_data_i,
    input  logic       src_valid_i,
    input  logic       src_last_i,
    output logic       src_ready_o,
    output logic       tgt_rst_n_o,
    output logic       tgt_sel_n_o,
    output logic       tgt_sck_o,
    output logic       tgt_mosi_o,
    input  logic       tgt_done_i,
    output logic       busy_o,
    output logic       ok_o,
    output logic       cfg_err_o,
    output logic       underflow_o
);
    localparam int TMAX2 = (CLEAR_CYC > RST_CYC) ? CLEAR_CYC : RST_CYC;
    localparam int TMAX  = (TMAX2 > CHECK_CYC) ? TMAX2 : CHECK_CYC;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int DBW   = $clog2(DUMMY_BITS + 1);
    localparam int LW    = $clog2(RST_CYC + 2);

    ld_state_t      state_q, state_d;
    logic           tmr_load, tmr_exp;
    logic [TW-1:0]  tmr_val;
    logic           sh_run, sh_load, sh_sck, sh_bit, bit_tick, byte_tick;
    logic           done_s1, done_s2;
    logic           last_seen_q;
    logic [DBW-1:0] dcnt_q;
    logic           ok_q, cerr_q, uflow_q;
    logic           ev_ok, ev_cerr, ev_uflow;

    cfg_loader_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .value_i(tmr_val), .expired_o(tmr_exp)
    );

    cfg_loader_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .run_i(sh_run), .load_i(sh_load),
        .byte_i(src_data_i), .sck_o(sh_sck), .bit_o(sh_bit),
        .bit_tick_o(bit_tick), .byte_tick_o(byte_tick)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        ev_ok    = 1'b0;
        ev_cerr  = 1'b0;
        ev_uflow = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESET:  if (tmr_exp) state_d = ST_CLEAR;
            ST_CLEAR:  if (tmr_exp) state_d = ST_FIRST;
            ST_FIRST:  if (src_valid_i) state_d = ST_STREAM;
            ST_STREAM: if (byte_tick) begin
                if (last_seen_q) begin
                    state_d = ST_CHECK;
                end else if (!src_valid_i) begin
                    state_d  = ST_IDLE;
                    ev_uflow = 1'b1;
                end
            end
            ST_CHECK:  if (tmr_exp) begin
                if (done_s2) begin
                    state_d = ST_TRAIL;
                end else begin
                    state_d = ST_IDLE;
                    ev_cerr = 1'b1;
                end
            end
            ST_TRAIL:  if (bit_tick && dcnt_q == DBW'(DUMMY_BITS - 1)) begin
                state_d = ST_IDLE;
                ev_ok   = 1'b1;
            end
            default:   state_d = ST_IDLE;
        endcase
        if (start_i) begin
            state_d  = ST_RESET;
            ev_ok    = 1'b0;
            ev_cerr  = 1'b0;
            ev_uflow = 1'b0;
        end
    end

    assign tmr_load = start_i || (state_d != state_q);
    always_comb begin
        unique case (state_d)
            ST_RESET: tmr_val = TW'(RST_CYC - 1);
            ST_CLEAR: tmr_val = TW'(CLEAR_CYC - 1);
            ST_CHECK: tmr_val = TW'(CHECK_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_s1     <= 1'b0;
            done_s2     <= 1'b0;
            last_seen_q <= 1'b0;
            dcnt_q      <= '0;
            ok_q        <= 1'b0;
            cerr_q      <= 1'b0;
            uflow_q     <= 1'b0;
        end else begin
            done_s1 <= tgt_done_i;
            done_s2 <= done_s1;
            if (start_i)                     last_seen_q <= 1'b0;
            else if (sh_load && src_last_i)  last_seen_q <= 1'b1;
            if (state_q != ST_TRAIL)         dcnt_q <= '0;
            else if (bit_tick)               dcnt_q <= dcnt_q + DBW'(1);
            if (start_i) begin
                ok_q    <= 1'b0;
                cerr_q  <= 1'b0;
                uflow_q <= 1'b0;
            end else begin
                if (ev_ok)    ok_q    <= 1'b1;
                if (ev_cerr)  cerr_q  <= 1'b1;
                if (ev_uflow) uflow_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tgt_rst_n_o = 1'b1;
        tgt_sel_n_o = 1'b0;
        tgt_sck_o   = 1'b0;
        tgt_mosi_o  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                tgt_sel_n_o = 1'b1;
                tgt_sck_o   = 1'b1;
            end
            ST_RESET: tgt_rst_n_o = 1'b0;
            ST_CLEAR, ST_FIRST: ;
            ST_STREAM, ST_CHECK, ST_TRAIL: begin
                tgt_sck_o  = sh_sck;
                tgt_mosi_o = sh_bit;
            end
            default: ;
        endcase
    end

    assign sh_run      = (state_q == ST_STREAM) || (state_q == ST_TRAIL);
    assign src_ready_o = !start_i && ((state_q == ST_FIRST) ||
                         (state_q == ST_STREAM && byte_tick && !last_seen_q));
    assign sh_load     = src_ready_o && src_valid_i;
    assign busy_o      = (state_q != ST_IDLE);
    assign ok_o        = ok_q;
    assign cfg_err_o   = cerr_q;
    assign underflow_o = uflow_q;

    // checker state: cycles the reset output has been low
    logic [LW-1:0] rlow_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rlow_q <= '0;
        else if (tgt_rst_n_o)       rlow_q <= '0;
        else if (rlow_q != '1)      rlow_q <= rlow_q + LW'(1);
    end

    // R1: pins parked whenever idle
    a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tgt_sel_n_o && tgt_rst_n_o && !src_ready_o));
    // R2: select low at release and the pulse is long enough
    a_r2_sel_low_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n_o) |-> !tgt_sel_n_o);
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n_o) |-> (rlow_q >= LW'(RST_CYC)));
    // R3: quiet during the clear wait
    a_r3_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && $past(state_q) == ST_CLEAR) |-> ($stable(tgt_sck_o) && !src_ready_o));
    // R5: bytes are taken only at a falling edge in the stream
    a_r5_load_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready_o && state_q == ST_STREAM) |-> tgt_sck_o);
    // R6: underflow ends the sequence
    a_r6_underflow_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ev_uflow |=> (!busy_o && underflow_o));
    // R9: restart always begins with reset low
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!tgt_rst_n_o && busy_o && !ok_o && !cfg_err_o && !underflow_o));
    // R10: at most one status flag
    a_r10_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, cfg_err_o, underflow_o}));
endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
    localparam int RST_CYC    = 26;
    localparam int CLEAR_CYC  = 300;
    localparam int HALF_DIV   = 3;
    localparam int CHECK_CYC  = 4;
    localparam int DUMMY_BITS = 49;
    localparam int TCLK_NS    = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [7:0] src_data_i;
    logic       src_valid_i, src_last_i, src_ready_o;
    logic       tgt_rst_n_o, tgt_sel_n_o, tgt_sck_o, tgt_mosi_o, tgt_done_i;
    logic       busy_o, ok_o, cfg_err_o, underflow_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [0:15];

    always #4 clk = ~clk;

    cfg_loader #(
        .RST_CYC(RST_CYC), .CLEAR_CYC(CLEAR_CYC), .HALF_DIV(HALF_DIV),
        .CHECK_CYC(CHECK_CYC), .DUMMY_BITS(DUMMY_BITS)
    ) u_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_last_i(src_last_i),
        .src_ready_o(src_ready_o), .tgt_rst_n_o(tgt_rst_n_o), .tgt_sel_n_o(tgt_sel_n_o),
        .tgt_sck_o(tgt_sck_o), .tgt_mosi_o(tgt_mosi_o), .tgt_done_i(tgt_done_i),
        .busy_o(busy_o), .ok_o(ok_o), .cfg_err_o(cfg_err_o), .underflow_o(underflow_o)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_parked(input string req);
        check(!busy_o && !src_ready_o, req, "busy/ready idle", {busy_o, src_ready_o}, 0);
        check({tgt_rst_n_o, tgt_sel_n_o, tgt_sck_o, tgt_mosi_o} == 4'hF, req, "pins parked",
              {tgt_rst_n_o, tgt_sel_n_o, tgt_sck_o, tgt_mosi_o}, 15);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        // R9: next cycle reset is low, status cleared, no byte requested
        check(!tgt_rst_n_o && !tgt_sel_n_o && busy_o, "R9", "reset pulse begins",
              {tgt_rst_n_o, tgt_sel_n_o, busy_o}, 1);
        check({ok_o, cfg_err_o, underflow_o} == 3'b000 && !src_ready_o, "R9", "status cleared",
              {ok_o, cfg_err_o, underflow_o}, 0);
    endtask

    // start and stall in the first-byte wait (source never valid)
    task automatic run_stall();
        src_valid_i = 1'b0;
        tgt_done_i  = 1'b0;
        pulse_start();
        while (!src_ready_o) @(negedge clk);
        check(busy_o && tgt_sck_o == 1'b0, "R3", "stalled before first byte", busy_o, 1);
    endtask

    task automatic run_load(input int len, input int stop_at, input bit give_done,
                            input int exp_ok, input int exp_err, input int exp_uf,
                            input int exp_trail);
        int rises = 0;
        int rcyc [0:511];
        bit rbit [0:511];
        int cyc = 0, low_cnt = 1, rel_cyc = -1, first_rdy = -1;
        int sel_bad = 0, mosi_bad = 0;
        bit psck = 1'b0, pmosi = 1'b1, prst = 1'b0;
        int sent, bad_space, bad_byte, trail_zero;
        tgt_done_i  = 1'b0;
        src_valid_i = 1'b0;
        pulse_start();
        fork
            begin : feeder
                int idx = 0;
                src_data_i  = img[0];
                src_last_i  = (len == 1);
                src_valid_i = (stop_at > 0);
                while (busy_o && src_valid_i) begin
                    @(negedge clk);
                    if (src_ready_o && src_valid_i) begin
                        @(posedge clk);
                        #1;
                        idx++;
                        if (idx >= len || idx >= stop_at) begin
                            src_valid_i = 1'b0;
                        end else begin
                            src_data_i = img[idx];
                            src_last_i = (idx == len - 1);
                        end
                    end
                end
            end
            begin : monitor
                bit go = 1'b1;
                while (go) begin
                    @(negedge clk);
                    cyc++;
                    if (busy_o) begin
                        if (tgt_sck_o && !psck && rises < 512) begin
                            rcyc[rises] = cyc;
                            rbit[rises] = tgt_mosi_o;
                            rises++;
                        end
                        if (tgt_sck_o && psck && tgt_mosi_o != pmosi) mosi_bad++;
                        if (!tgt_rst_n_o) low_cnt++;
                        if (tgt_rst_n_o && !prst) begin
                            rel_cyc = cyc;
                            if (tgt_sel_n_o) sel_bad++;
                        end
                        if (src_ready_o && first_rdy < 0) first_rdy = cyc;
                        if (give_done && rises == 8 * len) tgt_done_i = 1'b1;
                    end else begin
                        go = 1'b0;
                    end
                    psck  = tgt_sck_o;
                    pmosi = tgt_mosi_o;
                    prst  = tgt_rst_n_o;
                end
            end
        join
        sent = (stop_at < len) ? stop_at : len;
        check(low_cnt == RST_CYC, "R2", "reset low cycles", low_cnt, RST_CYC);
        check(sel_bad == 0 && rel_cyc > 0, "R2", "select low at release", sel_bad, 0);
        check(first_rdy - rel_cyc >= CLEAR_CYC, "R3", "clear wait", first_rdy - rel_cyc, CLEAR_CYC);
        check(rises > 0 && rcyc[0] > first_rdy, "R3", "no edge before data", rises, 1);
        check(rises == 8 * sent + exp_trail, "R7", "total rising edges", rises, 8 * sent + exp_trail);
        bad_space = 0;
        for (int i = 1; i < 8 * sent && i < rises; i++)
            if (rcyc[i] - rcyc[i-1] != 2 * HALF_DIV) bad_space++;
        check(bad_space == 0, "R5", "even spacing across image", bad_space, 0);
        bad_byte = 0;
        for (int b = 0; b < sent; b++)
            for (int k = 0; k < 8; k++)
                if (b * 8 + k < rises && rbit[b * 8 + k] != img[b][7 - k]) bad_byte++;
        check(bad_byte == 0, "R5", "msb-first bits", bad_byte, 0);
        check(mosi_bad == 0, "R4", "data stable while clock high", mosi_bad, 0);
        trail_zero = 0;
        for (int i = 8 * sent; i < rises; i++) begin
            if (!rbit[i]) trail_zero++;
            if (i > 8 * sent && rcyc[i] - rcyc[i-1] != 2 * HALF_DIV) trail_zero++;
        end
        check(trail_zero == 0, "R7", "trail bits high and evenly clocked", trail_zero, 0);
        check(ok_o == exp_ok[0], "R7", "ok flag", ok_o, exp_ok);
        check(cfg_err_o == exp_err[0], "R8", "config error flag", cfg_err_o, exp_err);
        check(underflow_o == exp_uf[0], "R6", "underflow flag", underflow_o, exp_uf);
        tgt_done_i = 1'b0;
        repeat (20) @(negedge clk);
        check({ok_o, cfg_err_o, underflow_o} == {exp_ok[0], exp_err[0], exp_uf[0]}, "R10",
              "status held", {ok_o, cfg_err_o, underflow_o}, {exp_ok[0], exp_err[0], exp_uf[0]});
        check_parked("R1");
    endtask

    task automatic load_image(input logic [7:0] b4, input logic [7:0] b5);
        img[0] = 8'h7E; img[1] = 8'hAA; img[2] = 8'h99; img[3] = 8'h7E;
        img[4] = b4;    img[5] = b5;
        for (int i = 6; i < 16; i++) img[i] = 8'(i * 37);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; src_data_i = '0; src_valid_i = 1'b0;
        src_last_i = 1'b0; tgt_done_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_parked("R1");
        check({ok_o, cfg_err_o, underflow_o} == 3'b000, "R1", "status after reset",
              {ok_o, cfg_err_o, underflow_o}, 0);
        // R4: programmed serial clock period inside the legal window
        check(2 * HALF_DIV * TCLK_NS >= 40 && 2 * HALF_DIV * TCLK_NS <= 1000, "R4",
              "sck period ns", 2 * HALF_DIV * TCLK_NS, 48);

        // good load, done high: R7
        load_image(8'h5A, 8'hC3);
        run_load(6, 6, 1'b1, 1, 0, 0, DUMMY_BITS);
        // done stays low: R8
        load_image(8'h01, 8'h80);
        run_load(6, 6, 1'b0, 0, 1, 0, 0);
        // source dries after three bytes: R6
        load_image(8'hFF, 8'h00);
        run_load(6, 3, 1'b0, 0, 0, 1, 0);
        // restart while waiting for the first byte, then a longer clean load: R9
        run_stall();
        load_image(8'h3C, 8'h96);
        run_load(10, 10, 1'b1, 1, 0, 0, DUMMY_BITS);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule